// File: doc/BRIEF.md
# Prioritised Edge/Level Interrupt Handler

This block collects 32 raw interrupt request lines and presents them to a processor as two interrupt outputs, a normal one and a fast one. Each line has its own configuration word. The word sets a 5-bit priority, selects edge or level sensitivity, and chooses which of the two outputs the line is routed to. Lines are latched into a pending register and gated by a mask register. For each output class, a priority arbiter picks one winning line from the pending, unmasked lines of that class.

Each output works through an agreement handshake. While the agreement for a class is armed and the class has an eligible line, the block latches the arbitration winner as that class's code and raises the output. The output then stays high until software writes the control register to issue a new agreement. Software reads a class's code register to learn the winning line number, and the read also acknowledges an edge-mode line. A software-trigger register raises one line as if its input had been asserted.

The register interface takes 32-bit word accesses on a simple select/write bus. Read data is returned combinationally in the same cycle. All side effects take place on the clock edge that ends the access.

Top module: `edge_level_intc`

## Requirements
- R1: After reset the mask register (offset 0x00 + 4) reads all ones, the pending register (offset 0x00) reads 0, every line configuration word reads 0, both code registers read 0, and both outputs are low.
- R2: An edge-mode line (configuration bit 1 = 0) becomes pending only on a 0-to-1 transition of its input. Releasing the input leaves the pending bit set.
- R3: A level-mode line (configuration bit 1 = 1) becomes pending while its input is high. Its pending bit clears when the input falls.
- R4: A write to offset 0x00 ANDs the pending bits with the written data. A level-mode line whose input is high stays pending.
- R5: Offset 0x04 holds the mask, and a 1 bit blocks that line from arbitration. A masked pending line never raises an output, and unmasking it lets the output rise.
- R6: The configuration word of line n sits at offset 0x1C + 4·n. Bits [6:2] hold the priority, bit 1 holds the sensitivity and bit 0 selects fast routing. Reads return exactly these seven bits, and all higher bits read as 0.
- R7: Among eligible lines, the lowest priority value wins, and equal priorities go to the higher line number. The winner is latched as the class code, and the output rises one cycle after an armed class has an eligible line.
- R8: A read of offset 0x10 (normal) or 0x14 (fast) returns the latched line number in bits [4:0]. The read clears that line's pending bit only if the line is in edge mode. Writes to these offsets change nothing.
- R9: Writing offset 0x18 with bit 0 set drops the normal output and re-arms its agreement, and bit 1 does the same for the fast output. The register reads as 0.
- R10: A write to offset 0x9C makes pending only the lowest-numbered set bit of the written data. The register reads as 0.
- R11: An access to an undecoded or misaligned offset reads 0, and a write to one changes no state.
- R12: A line with fast routing takes part only in the fast class, and its code is reported only at offset 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 32 | Raw interrupt request lines |
| busSel | input | 1 | Register access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while a read is selected |
| irqOut | output | 1 | Normal-class interrupt output |
| fiqOut | output | 1 | Fast-class interrupt output |

## Verification
The arbitration is driven three ways: by a single edge line, by three lines that go pending together with a priority tie, and by a software trigger that sets several bits at once. The tie case shows whether the higher line number wins. The successive re-agreements show that each acknowledge removes only the reported line. The software trigger shows that only the lowest set bit is taken. The edge and level patterns each hold the input high while software writes 0 to the pending register and while the code register is read, which separates the two sensitivity modes. Masking and fast routing are checked through which output rises and which code register names the line.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int CFG_BASE = 7;

  typedef struct packed {
    logic wrPend;
    logic wrMask;
    logic wrCfg;
    logic swTrig;
    logic ackNorm;
    logic ackFast;
    logic agrNorm;
    logic agrFast;
  } ctlStrobes_t;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_PEND,
    RD_MASK,
    RD_CODEN,
    RD_CODEF,
    RD_CFG
  } rdSel_t;
endpackage

// File: rtl/intc_prio_arb.sv
module intc_prio_arb #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W = 5,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]             req,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
  output logic                             anyReq,
  output logic [IDX_W-1:0]                 winIdx
);
  logic [PRIO_W-1:0] bestPrio;

  // Ascending scan with <= : lower value wins, a tie goes to the higher line.
  always_comb begin
    anyReq = 1'b0;
    bestPrio = '0;
    winIdx = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (req[i] && (!anyReq || prio[i] <= bestPrio)) begin
        anyReq = 1'b1;
        bestPrio = prio[i];
        winIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (anyReq) begin
      // R7
      win_is_request_chk: assert (req[winIdx]);
    end
  end
endmodule

// File: rtl/intc_regctl.sv
module intc_regctl
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  localparam int IDX_W = $clog2(NUM_LINES),
  localparam int SW_WORD = CFG_BASE + NUM_LINES
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        agrBits,
  output ctlStrobes_t       strb,
  output rdSel_t            rdSel,
  output logic [IDX_W-1:0]  cfgIdx
);
  logic [ADDR_W-3:0] word;
  logic aligned, isCfg, doWr, doRd;

  assign word = busAddr[ADDR_W-1:2];
  assign aligned = busAddr[1:0] == 2'b00;
  assign doWr = busSel && busWrite && aligned;
  assign doRd = busSel && !busWrite && aligned;
  assign isCfg = (int'(word) >= CFG_BASE) && (int'(word) < CFG_BASE + NUM_LINES);
  assign cfgIdx = IDX_W'(int'(word) - CFG_BASE);

  always_comb begin
    strb = '0;
    rdSel = RD_ZERO;
    if (doWr) begin
      if (word == 0) strb.wrPend = 1'b1;
      if (word == 1) strb.wrMask = 1'b1;
      if (word == 6) begin
        strb.agrNorm = agrBits[0];
        strb.agrFast = agrBits[1];
      end
      if (isCfg) strb.wrCfg = 1'b1;
      if (int'(word) == SW_WORD) strb.swTrig = 1'b1;
    end
    if (doRd) begin
      if (word == 0) rdSel = RD_PEND;
      if (word == 1) rdSel = RD_MASK;
      if (word == 4) begin
        rdSel = RD_CODEN;
        strb.ackNorm = 1'b1;
      end
      if (word == 5) begin
        rdSel = RD_CODEF;
        strb.ackFast = 1'b1;
      end
      if (isCfg) rdSel = RD_CFG;
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W = 5,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  ctlStrobes_t          strb,
  input  rdSel_t               rdSel,
  input  logic [IDX_W-1:0]     cfgIdx,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [1:0]           outQ
);
  logic [NUM_LINES-1:0] inQ, pendQ, maskQ, levelQ, fastQ;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prioQ;
  logic [1:0][IDX_W-1:0] codeQ;
  logic [1:0] armQ, ackV, agrV, anyV;
  logic [1:0][IDX_W-1:0] winV;
  logic [1:0][NUM_LINES-1:0] eligible;
  logic [NUM_LINES-1:0] wLines, rise, fall, setV, clrV, ackClr, swSet;

  assign wLines = wdata[NUM_LINES-1:0];
  assign ackV = {strb.ackFast, strb.ackNorm};
  assign agrV = {strb.agrFast, strb.agrNorm};
  assign rise = irqIn & ~inQ;
  assign fall = ~irqIn & inQ;
  assign swSet = strb.swTrig ? (wLines & (~wLines + 1'b1)) : '0;

  always_comb begin
    ackClr = '0;
    for (int c = 0; c < 2; c++)
      if (ackV[c] && !levelQ[codeQ[c]]) ackClr[codeQ[c]] = 1'b1;
  end

  assign setV = (~levelQ & rise) | (levelQ & irqIn) | swSet;
  assign clrV = (levelQ & fall) | ackClr
              | (strb.wrPend ? (~wLines & ~(levelQ & irqIn)) : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inQ <= '0;
      pendQ <= '0;
      maskQ <= '1;
      levelQ <= '0;
      fastQ <= '0;
      prioQ <= '0;
    end else begin
      inQ <= irqIn;
      pendQ <= (pendQ & ~clrV) | setV;
      if (strb.wrMask) maskQ <= wLines;
      if (strb.wrCfg) begin
        prioQ[cfgIdx] <= wdata[PRIO_W+1:2];
        levelQ[cfgIdx] <= wdata[1];
        fastQ[cfgIdx] <= wdata[0];
      end
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_class
    assign eligible[c] = pendQ & ~maskQ & (c == 1 ? fastQ : ~fastQ);

    intc_prio_arb #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_arb (
      .req(eligible[c]),
      .prio(prioQ),
      .anyReq(anyV[c]),
      .winIdx(winV[c])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        armQ[c] <= 1'b1;
        outQ[c] <= 1'b0;
        codeQ[c] <= '0;
      end else if (agrV[c]) begin
        armQ[c] <= 1'b1;
        outQ[c] <= 1'b0;
      end else if (armQ[c] && anyV[c]) begin
        armQ[c] <= 1'b0;
        outQ[c] <= 1'b1;
        codeQ[c] <= winV[c];
      end
    end

    // R9
    agr_drops_out_chk: assert property (@(posedge clk) disable iff (!rstN)
      agrV[c] |=> !outQ[c]);

    // R5
    raise_needs_unmasked_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(outQ[c]) |-> $past(|eligible[c]));
  end

  always_comb begin
    case (rdSel)
      RD_PEND:  rdata = DATA_W'(pendQ);
      RD_MASK:  rdata = DATA_W'(maskQ);
      RD_CODEN: rdata = DATA_W'(codeQ[0]);
      RD_CODEF: rdata = DATA_W'(codeQ[1]);
      RD_CFG:   rdata = DATA_W'({prioQ[cfgIdx], levelQ[cfgIdx], fastQ[cfgIdx]});
      default:  rdata = '0;
    endcase
  end

  // R3
  level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(levelQ & irqIn) & ~pendQ) == '0));

  // R2
  edge_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> (($past(pendQ & ~levelQ) & ~pendQ) == '0));
endmodule

// File: rtl/edge_level_intc.sv
module edge_level_intc
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W = 5,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 irqOut,
  output logic                 fiqOut
);
  ctlStrobes_t strb;
  rdSel_t rdSel;
  logic [IDX_W-1:0] cfgIdx;
  logic [1:0] outQ;

  intc_regctl #(.NUM_LINES(NUM_LINES)) u_ctl (
    .busSel(busSel),
    .busWrite(busWrite),
    .busAddr(busAddr),
    .agrBits(busWdata[1:0]),
    .strb(strb),
    .rdSel(rdSel),
    .cfgIdx(cfgIdx)
  );

  intc_datapath #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .irqIn(irqIn),
    .strb(strb),
    .rdSel(rdSel),
    .cfgIdx(cfgIdx),
    .wdata(busWdata),
    .rdata(busRdata),
    .outQ(outQ)
  );

  assign irqOut = outQ[0];
  assign fiqOut = outQ[1];
endmodule

// File: tb/edge_level_intc_test.sv
module edge_level_intc_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic busSel = 1'b0;
  logic busWrite = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irqOut, fiqOut;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [31:0] exp;
    string tag;
  } rdItem_t;
  rdItem_t sbQ[$];

  always #2.5 clk = ~clk;

  edge_level_intc uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  // Monitor: compares read data in mid-cycle against the scoreboard queue.
  always @(negedge clk) begin
    if (busSel && !busWrite) begin
      rdItem_t it;
      it = sbQ.pop_front();
      checks++;
      if (busRdata !== it.exp) begin
        failures++;
        $display("FAIL %s: read 0x%02h got 0x%08h expected 0x%08h",
                 it.tag, busAddr, busRdata, it.exp);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, input logic [31:0] e, input string tag);
    rdItem_t it;
    it.exp = e;
    it.tag = tag;
    sbQ.push_back(it);
    @(posedge clk); #1;
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  task automatic checkPins(input logic expIrq, input logic expFiq, input string tag);
    checks++;
    if (irqOut !== expIrq || fiqOut !== expFiq) begin
      failures++;
      $display("FAIL %s: outputs irq=%b fiq=%b expected irq=%b fiq=%b",
               tag, irqOut, fiqOut, expIrq, expFiq);
    end
  endtask

  function automatic logic [7:0] cfgAddr(input int n);
    return 8'(8'h1C + 4 * n);
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    failures++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    checkPins(1'b0, 1'b0, "R1");
    regRead(8'h04, 32'hFFFF_FFFF, "R1 mask");
    regRead(8'h00, 32'h0, "R1 pending");
    regRead(cfgAddr(0), 32'h0, "R1 cfg");
    regRead(8'h10, 32'h0, "R1 code");

    // R6 configuration word: line 5 level, priority 3; upper bits dropped
    regWrite(cfgAddr(5), 32'hFFFF_FF80 | 32'h0E);
    regRead(cfgAddr(5), 32'h0000_000E, "R6 cfg readback");

    // R2 edge line 3
    irqIn[3] = 1'b1; idle(2);
    regRead(8'h00, 32'h8, "R2 edge set");
    irqIn[3] = 1'b0; idle(2);
    regRead(8'h00, 32'h8, "R2 edge kept on release");
    regWrite(8'h00, 32'h0);
    irqIn[3] = 1'b1; idle(2);
    regWrite(8'h00, 32'h0);
    regRead(8'h00, 32'h0, "R2 held edge input no re-set");
    irqIn[3] = 1'b0; idle(2);

    // R3 / R4 level line 5
    irqIn[5] = 1'b1; idle(2);
    regRead(8'h00, 32'h20, "R3 level set");
    regWrite(8'h00, 32'h0);
    regRead(8'h00, 32'h20, "R4 level high survives clear");
    irqIn[5] = 1'b0; idle(2);
    regRead(8'h00, 32'h0, "R3 level release clears");

    // R5 masking, R8 ack of edge line, R9 re-arm
    irqIn[3] = 1'b1; idle(2);
    irqIn[3] = 1'b0; idle(2);
    checkPins(1'b0, 1'b0, "R5 masked no output");
    regWrite(8'h04, ~32'h8);
    idle(2);
    checkPins(1'b1, 1'b0, "R5 unmasked raises normal");
    regRead(8'h10, 32'd3, "R8 normal code");
    regRead(8'h00, 32'h0, "R8 edge ack clears");
    regWrite(8'h18, 32'h1);
    checkPins(1'b0, 1'b0, "R9 normal dropped");
    idle(2);
    checkPins(1'b0, 1'b0, "R9 nothing pending stays low");
    regRead(8'h18, 32'h0, "R9 control reads zero");

    // R7 arbitration: 8 prio 2, 9 prio 1, 10 prio 1
    regWrite(cfgAddr(8), 32'd2 << 2);
    regWrite(cfgAddr(9), 32'd1 << 2);
    regWrite(cfgAddr(10), 32'd1 << 2);
    regWrite(8'h04, 32'hFFFF_FFFF);
    irqIn[10:8] = 3'b111; idle(2);
    irqIn[10:8] = 3'b000; idle(1);
    regRead(8'h00, 32'h700, "R2 three edges pending");
    regWrite(8'h04, 32'h0);
    idle(2);
    checkPins(1'b1, 1'b0, "R7 output raised");
    regRead(8'h10, 32'd10, "R7 tie goes to higher line");
    regWrite(8'h18, 32'h1);
    regRead(8'h10, 32'd9, "R7 next winner");
    regWrite(8'h18, 32'h1);
    regRead(8'h10, 32'd8, "R7 last winner");
    regRead(8'h00, 32'h0, "R8 all acked");

    // R10 software trigger, R12 fast routing
    regWrite(cfgAddr(12), 32'h1);
    regWrite(8'h9C, 32'h0010_1000);
    regRead(8'h00, 32'h0000_1000, "R10 lowest bit only");
    checkPins(1'b1, 1'b1, "R12 fast raised");
    regRead(8'h10, 32'd8, "R12 normal code unchanged");
    regRead(8'h14, 32'd12, "R12 fast code");
    regRead(8'h00, 32'h0, "R8 fast edge ack");
    regRead(8'h9C, 32'h0, "R10 trigger reads zero");

    // R8 level line is not cleared by the code read; writes ignored
    regWrite(8'h18, 32'h1);
    checkPins(1'b0, 1'b1, "R9 normal re-armed");
    irqIn[5] = 1'b1; idle(3);
    checkPins(1'b1, 1'b1, "R3 level raises normal");
    regRead(8'h10, 32'd5, "R8 level code");
    regRead(8'h00, 32'h20, "R8 level not acked by read");
    regWrite(8'h10, 32'h1F);
    regRead(8'h10, 32'd5, "R8 code write ignored");
    irqIn[5] = 1'b0; idle(2);
    regRead(8'h00, 32'h0, "R3 level released");

    // R11 undecoded and misaligned accesses
    regWrite(8'h08, 32'hFFFF_FFFF);
    regRead(8'h08, 32'h0, "R11 undecoded reads zero");
    regWrite(8'h05, 32'hFFFF_FFFF);
    regRead(8'h04, 32'h0, "R11 misaligned write no effect");
    regRead(8'hA0, 32'h0, "R11 beyond map reads zero");

    // R9 fast agreement bit
    regWrite(8'h18, 32'h2);
    checkPins(1'b1, 1'b0, "R9 fast dropped");

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule